// File: doc/BRIEF.md
# SPI Controller Register Front End

This block is the register side of a serial peripheral controller. A host reaches it over a 64-bit register bus on which only full eight-byte accesses are legal. The word index is the byte address divided by eight. Accesses of any other length, and indices that have no register, read as all ones and leave every register unchanged on a write. Reads return data in the same cycle. Read and write side effects take place at the clock edge that ends the access.

Beside plain configuration storage, the block keeps the data-register status flags. It hands the transmit word, the eight sequencer op-code bytes and the clock configuration to the sequencer. It takes received words and transmit-consume strobes back from the sequencer. It also watches the clock-configuration reset field for a two-write unlock pattern (0x5 and then 0xA). When that pattern completes, the register loads its hard-reset value and a one-cycle reset event is raised for the rest of the controller.

Top module: `spi_ctl_regs`

## Requirements
- R1: A bus access is legal only when `bus_len` is 8, and the word index is `bus_addr >> 3`, so the low three address bits are ignored. A write of any other length changes nothing, and a read of any other length returns all ones.
- R2: The word indices are: error 0, counter config 1, config 2, clock config 3, memory-map config 4, transmit data 5, receive data 6, sequencer ops 7, status 8. A read of any other index returns all ones, and a write to any other index is ignored.
- R3: The error, counter config, config, memory-map config and receive data registers read back exactly what the bus last wrote to them.
- R4: A legal read of receive data returns the stored word and clears the receive-full flag at the end of the access.
- R5: A write to transmit data stores the word, drives it on `tx_data`, sets transmit-full and clears transmit-underrun.
- R6: When the reset field (bits 59:56) of clock config holds 0x5 and a write carries 0xA in that field, clock config loads 0x0C00_0000_0000_0000, and `ctl_reset_evt` is high for the one cycle after the write.
- R7: Every other clock-config write stores the written value unchanged, including a 0xA write when the field does not hold 0x5.
- R8: In the sequencer ops register, op byte i is bits 63-8i down to 56-8i of the written word. A read returns the bytes in the same positions, and `op_codes` shows the same word.
- R9: The status word has receive-full at bit 63, receive-overrun at bit 62, transmit-full at bit 61, transmit-overrun at bit 60, transmit-underrun at bit 59, and zeros elsewhere. A status write copies only written bits 62 and 60 into the two overrun flags.
- R10: A `seq_load` pulse writes `seq_rx_data` into receive data and sets receive-full. If receive-full is already set, it also sets receive-overrun.
- R11: A `seq_consume` pulse clears transmit-full. If transmit-full is already clear, it sets transmit-underrun instead.
- R12: Synchronous reset clears every register, flag and op byte, and sets clock config to 0x0C00_0000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_len | input | 4 | Access length in bytes |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid while `bus_rd` is high |
| seq_load | input | 1 | Sequencer delivers a received word |
| seq_rx_data | input | 64 | Received word |
| seq_consume | input | 1 | Sequencer took the transmit word |
| tx_data | output | 64 | Stored transmit word |
| op_codes | output | 64 | Eight op-code bytes, byte 0 in the top bits |
| clk_cfg | output | 64 | Clock configuration word |
| ctl_reset_evt | output | 1 | One-cycle controller reset request |
| tdr_full | output | 1 | Transmit-full flag |
| rdr_full | output | 1 | Receive-full flag |

## Verification
The clock-config field is driven with several sequences. The 0x5-then-0xA pair separates the unlock path from a plain store. A 0xA written over the hard value, and a 0x5 followed by 0x7, show that only the exact pair triggers. The flags are driven by single and back-to-back sequencer loads and consumes: a second load must raise overrun, and a consume on an empty register must raise underrun, while single events must not. The bus is also exercised with short lengths, an unaligned address, unmapped indices, and a status write carrying ones in every bit, so that only the two overrun bits may respond.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int DW   = 64;
  localparam int NREG = 9;

  localparam int IDX_ERR = 0;
  localparam int IDX_CTR = 1;
  localparam int IDX_CFG = 2;
  localparam int IDX_CLK = 3;
  localparam int IDX_MM  = 4;
  localparam int IDX_TDR = 5;
  localparam int IDX_RDR = 6;
  localparam int IDX_SEQ = 7;
  localparam int IDX_STS = 8;

  localparam int ST_RFULL = 63;
  localparam int ST_ROVR  = 62;
  localparam int ST_TFULL = 61;
  localparam int ST_TOVR  = 60;
  localparam int ST_TUNR  = 59;

  // op byte i sits at the top end of the word for i = 0
  function automatic logic [7:0] op_byte(input logic [DW-1:0] w, input int i);
    return w[DW-1-8*i -: 8];
  endfunction

  function automatic logic [3:0] rst_field(input logic [DW-1:0] w, input int lsb);
    return w[lsb +: 4];
  endfunction

  function automatic logic [DW-1:0] pack_status(input logic rf, input logic ro,
                                                input logic tf, input logic to,
                                                input logic tu);
    logic [DW-1:0] s;
    s = '0;
    s[ST_RFULL] = rf;
    s[ST_ROVR]  = ro;
    s[ST_TFULL] = tf;
    s[ST_TOVR]  = to;
    s[ST_TUNR]  = tu;
    return s;
  endfunction
endpackage

// File: rtl/spi_rb_decode.sv
module spi_rb_decode #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 9,
  localparam int IDX_W = ADDR_W - 3
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_len,
  output logic [NREG-1:0]   wr_sel,
  output logic [NREG-1:0]   rd_sel,
  output logic              rd_ok,
  output logic [IDX_W-1:0]  idx
);
  logic legal;
  logic [2:0] lane_ignored;

  assign legal        = (bus_len == 4'd8);
  assign idx          = bus_addr[ADDR_W-1:3];
  assign lane_ignored = bus_addr[2:0];
  assign rd_ok        = bus_rd && legal;

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign wr_sel[g] = bus_wr && legal && (idx == IDX_W'(g));
    assign rd_sel[g] = rd_ok && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/spi_rb_seqops.sv
module spi_rb_seqops #(
  parameter int NBYTE = 8,
  localparam int W = NBYTE * 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ops
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (wr) q <= wdata[W-1-8*b -: 8];
    end
    assign ops[W-1-8*b -: 8] = q;
  end
endmodule

// File: rtl/spi_rb_status.sv
module spi_rb_status (
  input  logic clk,
  input  logic rst,
  input  logic tdr_wr_evt,
  input  logic rdr_rd_evt,
  input  logic sts_wr_evt,
  input  logic w_rovr,
  input  logic w_tovr,
  input  logic seq_load,
  input  logic seq_consume,
  output logic rdr_full,
  output logic rdr_ovr,
  output logic tdr_full,
  output logic tdr_ovr,
  output logic tdr_unr
);
  logic load_over_evt;
  logic consume_empty_evt;

  assign load_over_evt     = seq_load && rdr_full;
  assign consume_empty_evt = seq_consume && !tdr_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdr_full <= 1'b0;
      rdr_ovr  <= 1'b0;
      tdr_full <= 1'b0;
      tdr_ovr  <= 1'b0;
      tdr_unr  <= 1'b0;
    end else begin
      if (seq_load)        rdr_full <= 1'b1;
      else if (rdr_rd_evt) rdr_full <= 1'b0;

      if (load_over_evt)   rdr_ovr <= 1'b1;
      else if (sts_wr_evt) rdr_ovr <= w_rovr;

      if (tdr_wr_evt)       tdr_full <= 1'b1;
      else if (seq_consume) tdr_full <= 1'b0;

      if (tdr_wr_evt)             tdr_unr <= 1'b0;
      else if (consume_empty_evt) tdr_unr <= 1'b1;

      if (sts_wr_evt) tdr_ovr <= w_tovr;
    end
  end

  assert_rfull_on_load_R10: assert property (@(posedge clk) disable iff (rst)
    seq_load |=> rdr_full);
  assert_rovr_on_second_load_R10: assert property (@(posedge clk) disable iff (rst)
    load_over_evt |=> rdr_ovr);
  assert_tdr_write_flags_R5: assert property (@(posedge clk) disable iff (rst)
    tdr_wr_evt |=> (tdr_full && !tdr_unr));
  assert_underrun_on_empty_R11: assert property (@(posedge clk) disable iff (rst)
    (consume_empty_evt && !tdr_wr_evt) |=> tdr_unr);
  assert_read_clears_rfull_R4: assert property (@(posedge clk) disable iff (rst)
    (rdr_rd_evt && !seq_load) |=> !rdr_full);
endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
  import spi_rb_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          RST_LSB  = 56,
  parameter logic [63:0] HARD_RST = 64'h0C00_0000_0000_0000,
  parameter logic [3:0]  UNLOCK_A = 4'h5,
  parameter logic [3:0]  UNLOCK_B = 4'hA,
  localparam int         IDX_W    = ADDR_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_len,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              seq_load,
  input  logic [DW-1:0]     seq_rx_data,
  input  logic              seq_consume,
  output logic [DW-1:0]     tx_data,
  output logic [DW-1:0]     op_codes,
  output logic [DW-1:0]     clk_cfg,
  output logic              ctl_reset_evt,
  output logic              tdr_full,
  output logic              rdr_full
);
  logic [NREG-1:0]  wr_sel, rd_sel;
  logic             rd_ok;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    err_q, ctr_q, cfg_q, mm_q, rdr_q;
  logic             rdr_ovr, tdr_ovr, tdr_unr;
  logic             unlock_evt;

  spi_rb_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) dec_i (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_len(bus_len),
    .wr_sel(wr_sel), .rd_sel(rd_sel), .rd_ok(rd_ok), .idx(idx)
  );

  spi_rb_seqops #(.NBYTE(DW / 8)) ops_i (
    .clk(clk), .rst(rst), .wr(wr_sel[IDX_SEQ]), .wdata(bus_wdata), .ops(op_codes)
  );

  spi_rb_status sts_i (
    .clk(clk), .rst(rst),
    .tdr_wr_evt(wr_sel[IDX_TDR]), .rdr_rd_evt(rd_sel[IDX_RDR]),
    .sts_wr_evt(wr_sel[IDX_STS]),
    .w_rovr(bus_wdata[ST_ROVR]), .w_tovr(bus_wdata[ST_TOVR]),
    .seq_load(seq_load), .seq_consume(seq_consume),
    .rdr_full(rdr_full), .rdr_ovr(rdr_ovr), .tdr_full(tdr_full),
    .tdr_ovr(tdr_ovr), .tdr_unr(tdr_unr)
  );

  assign unlock_evt = wr_sel[IDX_CLK]
                   && (rst_field(clk_cfg, RST_LSB) == UNLOCK_A)
                   && (rst_field(bus_wdata, RST_LSB) == UNLOCK_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= '0; ctr_q <= '0; cfg_q <= '0; mm_q <= '0;
      rdr_q <= '0; tx_data <= '0;
      clk_cfg <= HARD_RST;
      ctl_reset_evt <= 1'b0;
    end else begin
      if (wr_sel[IDX_ERR]) err_q <= bus_wdata;
      if (wr_sel[IDX_CTR]) ctr_q <= bus_wdata;
      if (wr_sel[IDX_CFG]) cfg_q <= bus_wdata;
      if (wr_sel[IDX_MM])  mm_q  <= bus_wdata;
      if (wr_sel[IDX_TDR]) tx_data <= bus_wdata;
      if (seq_load)             rdr_q <= seq_rx_data;
      else if (wr_sel[IDX_RDR]) rdr_q <= bus_wdata;
      if (unlock_evt)           clk_cfg <= HARD_RST;
      else if (wr_sel[IDX_CLK]) clk_cfg <= bus_wdata;
      ctl_reset_evt <= unlock_evt;
    end
  end

  always_comb begin
    bus_rdata = '1;
    if (rd_ok) begin
      case (int'(idx))
        IDX_ERR: bus_rdata = err_q;
        IDX_CTR: bus_rdata = ctr_q;
        IDX_CFG: bus_rdata = cfg_q;
        IDX_CLK: bus_rdata = clk_cfg;
        IDX_MM:  bus_rdata = mm_q;
        IDX_TDR: bus_rdata = tx_data;
        IDX_RDR: bus_rdata = rdr_q;
        IDX_SEQ: bus_rdata = op_codes;
        IDX_STS: bus_rdata = pack_status(rdr_full, rdr_ovr, tdr_full, tdr_ovr, tdr_unr);
        default: bus_rdata = '1;
      endcase
    end
  end

  assert_unlock_hard_value_R6: assert property (@(posedge clk) disable iff (rst)
    unlock_evt |=> (clk_cfg == HARD_RST && ctl_reset_evt));
  assert_plain_clk_store_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_sel[IDX_CLK] && !unlock_evt) |=> (clk_cfg == $past(bus_wdata)));
  assert_short_read_ones_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_len != 4'd8) |-> (bus_rdata == '1));
  assert_short_write_keeps_err_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_len != 4'd8) |=> $stable(err_q));
  assert_one_write_target_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));
endmodule

// File: tb/spi_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module spi_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd, seq_load, seq_consume;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_len;
  logic [63:0] bus_wdata, seq_rx_data;
  logic [63:0] bus_rdata, tx_data, op_codes, clk_cfg;
  logic        ctl_reset_evt, tdr_full, rdr_full;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { logic [63:0] d; string tag; } exp_t;
  exp_t exp_q[$];

  localparam logic [63:0] HARD = 64'h0C00_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  always #2.5 clk = ~clk;

  spi_ctl_regs dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_len(bus_len), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seq_load(seq_load), .seq_rx_data(seq_rx_data), .seq_consume(seq_consume),
    .tx_data(tx_data), .op_codes(op_codes), .clk_cfg(clk_cfg),
    .ctl_reset_evt(ctl_reset_evt), .tdr_full(tdr_full), .rdr_full(rdr_full)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read data mid-cycle, after the driver has settled
  always @(negedge clk) begin
    #1;
    if (bus_rd) begin
      if (exp_q.size() == 0) chk("scoreboard-empty", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, bus_rdata, e.d);
      end
    end
  end

  task automatic wr(input int idx, input logic [63:0] d, input logic [3:0] len = 4'd8);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'(idx << 3); bus_len = len; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_a(input logic [7:0] a, input logic [63:0] e, input string tag,
                      input logic [3:0] len = 4'd8);
    exp_t x;
    @(negedge clk);
    x.d = e; x.tag = tag;
    exp_q.push_back(x);
    bus_rd = 1'b1; bus_addr = a; bus_len = len;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd(input int idx, input logic [63:0] e, input string tag);
    rd_a(8'(idx << 3), e, tag);
  endtask

  task automatic load(input logic [63:0] d);
    @(negedge clk);
    seq_load = 1'b1; seq_rx_data = d;
    @(negedge clk);
    seq_load = 1'b0;
  endtask

  task automatic consume();
    @(negedge clk);
    seq_consume = 1'b1;
    @(negedge clk);
    seq_consume = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      chk("watchdog", 64'd1, 64'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_len = 8;
    bus_wdata = 0; seq_load = 0; seq_rx_data = 0; seq_consume = 0;
    do_reset();

    // R12 reset state
    rd(3, HARD, "R12 clk cfg reset");
    rd(8, 64'd0, "R12 status reset");
    rd(7, 64'd0, "R12 ops reset");
    chk("R12 flags reset", {62'd0, tdr_full, rdr_full}, 64'd0);

    // R3 plain storage
    wr(0, 64'h1111_2222_3333_4444);
    wr(1, 64'hA5A5_5A5A_A5A5_5A5A);
    wr(2, 64'h0123_4567_89AB_CDEF);
    wr(4, 64'hFEDC_BA98_7654_3210);
    wr(6, 64'h5555_AAAA_5555_AAAA);
    rd(0, 64'h1111_2222_3333_4444, "R3 error");
    rd(1, 64'hA5A5_5A5A_A5A5_5A5A, "R3 counter cfg");
    rd(2, 64'h0123_4567_89AB_CDEF, "R3 cfg");
    rd(4, 64'hFEDC_BA98_7654_3210, "R3 mm cfg");
    rd(6, 64'h5555_AAAA_5555_AAAA, "R3 rx data");

    // R1 access length and low address bits
    wr(0, 64'hDEAD_BEEF, 4'd4);
    rd(0, 64'h1111_2222_3333_4444, "R1 short write ignored");
    rd_a(8'h00, ONES, "R1 short read ones", 4'd4);
    rd_a(8'h15, 64'h0123_4567_89AB_CDEF, "R1 unaligned index");

    // R2 unmapped
    rd(20, ONES, "R2 unmapped idx 20");
    rd(9, ONES, "R2 unmapped idx 9");
    wr(20, 64'h0);
    rd(0, 64'h1111_2222_3333_4444, "R2 unmapped write ignored");

    // R5 transmit write
    wr(5, 64'h1122_3344_5566_7788);
    chk("R5 tx_data", tx_data, 64'h1122_3344_5566_7788);
    rd(8, 64'h2000_0000_0000_0000, "R5 status tfull");
    rd(5, 64'h1122_3344_5566_7788, "R5 tdr readback");

    // R11 consume
    consume();
    chk("R11 consume clears tfull", {63'd0, tdr_full}, 64'd0);
    consume();
    rd(8, 64'h0800_0000_0000_0000, "R11 underrun");
    wr(5, 64'h99);
    rd(8, 64'h2000_0000_0000_0000, "R5 write clears underrun");

    // R10 / R4 receive side
    load(64'hAAAA_0000_AAAA_0000);
    chk("R10 rfull", {63'd0, rdr_full}, 64'd1);
    rd(8, 64'hA000_0000_0000_0000, "R10 single load no overrun");
    load(64'hBBBB_0000_BBBB_0000);
    rd(8, 64'hE000_0000_0000_0000, "R10 overrun");
    rd(6, 64'hBBBB_0000_BBBB_0000, "R4 rx read value");
    chk("R4 rfull cleared", {63'd0, rdr_full}, 64'd0);
    rd(8, 64'h6000_0000_0000_0000, "R4 status after read");

    // R9 status write
    wr(8, 64'hBFFF_FFFF_FFFF_FFFF);
    rd(8, 64'h3000_0000_0000_0000, "R9 only overruns written");
    wr(8, 64'h4000_0000_0000_0000);
    rd(8, 64'h6000_0000_0000_0000, "R9 rovr set tovr clear");
    wr(8, 64'h0);
    rd(8, 64'h2000_0000_0000_0000, "R9 clear overruns");

    // R8 op byte order
    wr(7, 64'h0102_0304_0506_0708);
    rd(7, 64'h0102_0304_0506_0708, "R8 ops readback");
    chk("R8 byte0 top", {56'd0, op_codes[63:56]}, 64'h01);
    chk("R8 byte7 bottom", {56'd0, op_codes[7:0]}, 64'h08);

    // R6 / R7 unlock
    wr(3, 64'h0500_0000_0000_00FF);
    rd(3, 64'h0500_0000_0000_00FF, "R7 store 5");
    wr(3, 64'h0A00_0000_0000_0033);
    chk("R6 reset event", {63'd0, ctl_reset_evt}, 64'd1);
    @(negedge clk);
    chk("R6 event one cycle", {63'd0, ctl_reset_evt}, 64'd0);
    rd(3, HARD, "R6 hard value");
    chk("R6 clk_cfg port", clk_cfg, HARD);
    wr(3, 64'h0A00_0000_0000_0033);
    rd(3, 64'h0A00_0000_0000_0033, "R7 A without 5");
    chk("R7 no event", {63'd0, ctl_reset_evt}, 64'd0);
    wr(3, 64'h0500_0000_0000_0000);
    wr(3, 64'h0700_0000_0000_0001);
    rd(3, 64'h0700_0000_0000_0001, "R7 5 then 7");

    // R12 mid-run reset
    do_reset();
    rd(3, HARD, "R12 clk cfg after reset");
    rd(7, 64'd0, "R12 ops after reset");
    rd(0, 64'd0, "R12 error after reset");
    rd(8, 64'd0, "R12 status after reset");

    @(negedge clk);
    @(negedge clk);
    if (exp_q.size() != 0) chk("scoreboard-leftover", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule